// File: doc/BRIEF.md
# Alarm-Driven Power-Enable Sequencer

This block owns the enable pin of an external power-management device. Out of reset the pin is driven active, so the system is powered. Software arms the sequencer through a 32-bit configuration register. Once armed, a second-alarm event switches the pin off and the system powers down. A set of external wakeup inputs then switches it back on. Each wakeup input has its own enable bit and its own polarity bit.

The alarm comparator sits outside the block and reports a hit on `alarm2_match_i`. A match counts as an event only while the second-alarm interrupt enable is set. An event sets a sticky status flag, which raises `irq_o` while enabled and is cleared by writing one to it. Software normally places the alarm at least two seconds after the current time. Each wakeup input passes through a two-flop synchronizer before it is used.

Top module: `alarm_power_seq`

## Requirements
- R1: After reset `pwr_en_o` is 1, `cfg_rdata_o` reads 0x000000F0, `irq_en_o` reads 0, `stat_o` reads 0 and `irq_o` is 0.
- R2: Configuration bit 16 is the power-control arm bit, bits 0..3 are the wakeup enables for inputs 0..3 and bits 4..7 are their polarities; only these nine bits are stored, and all other bits read 0.
- R3: While configuration bit 16 reads 0, `pwr_en_o` is 1 on the next cycle, whatever the alarm and wakeup inputs do; clearing the bit while the pin is off restores it on the second clock edge after the write.
- R4: A second-alarm event is `alarm2_match_i` high at a clock edge while `irq_en_o` bit 4 is 1; with bit 16 set and no wakeup active, `pwr_en_o` goes to 0 after that edge.
- R5: `alarm2_match_i` while `irq_en_o` bit 4 is 0 sets no flag and leaves `pwr_en_o` unchanged.
- R6: `stat_o` bit 7 is set by a second-alarm event and cleared by a status write with data bit 7 = 1; a write with bit 7 = 0 leaves it unchanged, and an event in the same cycle as a clear leaves it set.
- R7: Only bit 4 of the interrupt-enable register is stored (others read 0); `irq_o` is 1 exactly while `stat_o` bit 7 and `irq_en_o` bit 4 are both 1.
- R8: An enabled wakeup input at its active level turns `pwr_en_o` back to 1; after the input changes, the pin is still 0 after two clock edges and is 1 after the third.
- R9: Polarity bit 4+n set means input n is active low, and cleared means active high; a disabled input, or an input at its inactive level, has no effect.
- R10: If a wakeup is active in the same cycle as a second-alarm event, the wakeup wins and `pwr_en_o` stays 1.
- R11: Once off, `pwr_en_o` stays 0 while no enabled wakeup is active and bit 16 stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration register readback |
| irq_en_we_i | input | 1 | Interrupt-enable write strobe |
| irq_en_wdata_i | input | 8 | Interrupt-enable write data (bit 4 = second alarm) |
| irq_en_o | output | 8 | Interrupt-enable readback |
| stat_we_i | input | 1 | Status write strobe (write one to clear) |
| stat_wdata_i | input | 8 | Status write data (bit 7 clears the alarm flag) |
| stat_o | output | 8 | Status readback (bit 7 = second-alarm flag) |
| alarm2_match_i | input | 1 | Second-alarm comparator hit |
| wake_i | input | 4 | Asynchronous external wakeup inputs |
| pwr_en_o | output | 1 | Power-enable pin, 1 = system powered |
| irq_o | output | 1 | Second-alarm interrupt |

## Verification
Two events can arrive in the same cycle. A second-alarm event can coincide with an active wakeup, and a flag-clear write can coincide with a new event. The bench provokes the first case by holding an enabled wakeup input at its active level for longer than the synchronizer delay and then pulsing the alarm match. It passes only if the pin stays on while the flag still sets. It provokes the second case by driving the status clear and the match in the same cycle, and passes only if the flag reads set afterwards.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int unsigned CTRL_W        = 32;
  localparam int unsigned N_WAKE_DEF    = 4;
  localparam int unsigned SYNC_DEF      = 2;
  localparam int unsigned PWR_CTL_BIT   = 16;
  localparam int unsigned WAKE_EN_LSB   = 0;
  localparam int unsigned IRQ_W         = 8;
  localparam int unsigned IRQ_ALM2_BIT  = 4;
  localparam int unsigned STAT_ALM2_BIT = 7;

  typedef enum logic {
    PWR_OFF = 1'b0,
    PWR_ON  = 1'b1
  } pwr_state_e;
endpackage

// File: rtl/pwr_cfg_reg.sv
module pwr_cfg_reg
  import pwr_seq_pkg::*;
#(
  parameter int unsigned N_WAKE = N_WAKE_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [N_WAKE-1:0] wake_en_o,
  output logic [N_WAKE-1:0] wake_pol_o,
  output logic              ctl_en_o,
  output logic [CTRL_W-1:0] rdata_o
);
  localparam int unsigned POL_LSB = WAKE_EN_LSB + N_WAKE;

  logic [N_WAKE-1:0] en_q, pol_q;
  logic              ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      pol_q <= '1;  // active low by default
      ctl_q <= 1'b0;
    end else if (we_i) begin
      en_q  <= wdata_i[WAKE_EN_LSB +: N_WAKE];
      pol_q <= wdata_i[POL_LSB +: N_WAKE];
      ctl_q <= wdata_i[PWR_CTL_BIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[WAKE_EN_LSB +: N_WAKE] = en_q;
    rdata_o[POL_LSB +: N_WAKE]     = pol_q;
    rdata_o[PWR_CTL_BIT]           = ctl_q;
  end

  assign wake_en_o  = en_q;
  assign wake_pol_o = pol_q;
  assign ctl_en_o   = ctl_q;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;
endmodule

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync
  import pwr_seq_pkg::*;
#(
  parameter int unsigned N_WAKE      = N_WAKE_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_WAKE-1:0] wake_i,
  input  logic [N_WAKE-1:0] en_i,
  input  logic [N_WAKE-1:0] pol_i,
  output logic              hit_o
);
  logic [N_WAKE-1:0] lvl;

  for (genvar g = 0; g < N_WAKE; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[SYNC_STAGES-2:0], wake_i[g]};
    end
    assign lvl[g] = sh_q[SYNC_STAGES-1];
  end

  // pol=1 -> active when level is low
  assign hit_o = |(en_i & (lvl ^ pol_i));
endmodule

// File: rtl/pwr_alarm_stat.sv
module pwr_alarm_stat
  import pwr_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_en_we_i,
  input  logic [IRQ_W-1:0] irq_en_wdata_i,
  input  logic             stat_we_i,
  input  logic [IRQ_W-1:0] stat_wdata_i,
  input  logic             match_i,
  output logic             evt_o,
  output logic [IRQ_W-1:0] irq_en_o,
  output logic [IRQ_W-1:0] stat_o,
  output logic             irq_o
);
  logic en_q, flag_q;

  assign evt_o = match_i & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          en_q <= 1'b0;
    else if (irq_en_we_i) en_q <= irq_en_wdata_i[IRQ_ALM2_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                       flag_q <= 1'b0;
    else if (evt_o)                                    flag_q <= 1'b1;
    else if (stat_we_i && stat_wdata_i[STAT_ALM2_BIT]) flag_q <= 1'b0;
  end

  always_comb begin
    irq_en_o = '0;
    irq_en_o[IRQ_ALM2_BIT] = en_q;
    stat_o = '0;
    stat_o[STAT_ALM2_BIT] = flag_q;
  end

  assign irq_o = flag_q & en_q;

  logic unused_wr;
  assign unused_wr = ^{irq_en_wdata_i, stat_wdata_i};
endmodule

// File: rtl/pwr_en_fsm.sv
module pwr_en_fsm
  import pwr_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctl_en_i,
  input  logic alarm_evt_i,
  input  logic wake_hit_i,
  output logic pwr_en_o
);
  pwr_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!ctl_en_i) st_d = PWR_ON;
    else begin
      unique case (st_q)
        PWR_ON:  if (alarm_evt_i && !wake_hit_i) st_d = PWR_OFF;
        PWR_OFF: if (wake_hit_i)                 st_d = PWR_ON;
        default: st_d = PWR_ON;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= PWR_ON;
    else         st_q <= st_d;
  end

  assign pwr_en_o = (st_q == PWR_ON);
endmodule

// File: rtl/alarm_power_seq.sv
module alarm_power_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned N_WAKE      = N_WAKE_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CTRL_W-1:0] cfg_wdata_i,
  output logic [CTRL_W-1:0] cfg_rdata_o,
  input  logic              irq_en_we_i,
  input  logic [IRQ_W-1:0]  irq_en_wdata_i,
  output logic [IRQ_W-1:0]  irq_en_o,
  input  logic              stat_we_i,
  input  logic [IRQ_W-1:0]  stat_wdata_i,
  output logic [IRQ_W-1:0]  stat_o,
  input  logic              alarm2_match_i,
  input  logic [N_WAKE-1:0] wake_i,
  output logic              pwr_en_o,
  output logic              irq_o
);
  logic [N_WAKE-1:0] wake_en, wake_pol;
  logic              ctl_en, alarm_evt, wake_hit;

  pwr_cfg_reg #(.N_WAKE(N_WAKE)) u_cfg (
    .clk_i, .rst_ni,
    .we_i       (cfg_we_i),
    .wdata_i    (cfg_wdata_i),
    .wake_en_o  (wake_en),
    .wake_pol_o (wake_pol),
    .ctl_en_o   (ctl_en),
    .rdata_o    (cfg_rdata_o)
  );

  pwr_wake_sync #(.N_WAKE(N_WAKE), .SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk_i, .rst_ni,
    .wake_i (wake_i),
    .en_i   (wake_en),
    .pol_i  (wake_pol),
    .hit_o  (wake_hit)
  );

  pwr_alarm_stat u_alarm (
    .clk_i, .rst_ni,
    .irq_en_we_i    (irq_en_we_i),
    .irq_en_wdata_i (irq_en_wdata_i),
    .stat_we_i      (stat_we_i),
    .stat_wdata_i   (stat_wdata_i),
    .match_i        (alarm2_match_i),
    .evt_o          (alarm_evt),
    .irq_en_o       (irq_en_o),
    .stat_o         (stat_o),
    .irq_o          (irq_o)
  );

  pwr_en_fsm u_fsm (
    .clk_i, .rst_ni,
    .ctl_en_i    (ctl_en),
    .alarm_evt_i (alarm_evt),
    .wake_hit_i  (wake_hit),
    .pwr_en_o    (pwr_en_o)
  );
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk
  import pwr_seq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctl_en_i,
  input logic             wake_hit_i,
  input logic             match_i,
  input logic [IRQ_W-1:0] irq_en_i,
  input logic             stat_we_i,
  input logic [IRQ_W-1:0] stat_wdata_i,
  input logic [IRQ_W-1:0] stat_i,
  input logic             pwr_en_i,
  input logic             irq_i
);
  logic evt;
  assign evt = match_i && irq_en_i[IRQ_ALM2_BIT];

  a_r3_hold_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_en_i |=> pwr_en_i);

  a_r4_alarm_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_en_i && evt && !wake_hit_i |=> !pwr_en_i);

  a_r8_wake_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_en_i && wake_hit_i |=> pwr_en_i);

  a_r11_stay_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_en_i && !pwr_en_i && !wake_hit_i |=> !pwr_en_i);

  a_r6_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> stat_i[STAT_ALM2_BIT]);

  a_r6_flag_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_we_i && stat_wdata_i[STAT_ALM2_BIT] && !evt |=> !stat_i[STAT_ALM2_BIT]);

  a_r7_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> ($rose(stat_i[STAT_ALM2_BIT]) || $rose(irq_en_i[IRQ_ALM2_BIT])));
endmodule

bind alarm_power_seq pwr_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctl_en_i     (ctl_en),
  .wake_hit_i   (wake_hit),
  .match_i      (alarm2_match_i),
  .irq_en_i     (irq_en_o),
  .stat_we_i    (stat_we_i),
  .stat_wdata_i (stat_wdata_i),
  .stat_i       (stat_o),
  .pwr_en_i     (pwr_en_o),
  .irq_i        (irq_o)
);

// File: tb/alarm_power_seq_test.sv
module alarm_power_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, irq_we, stat_we, match;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [7:0]  irq_wdata, irq_en, stat_wdata, stat;
  logic [3:0]  wake;
  logic        pwr_en, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_power_seq uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .irq_en_we_i(irq_we), .irq_en_wdata_i(irq_wdata), .irq_en_o(irq_en),
    .stat_we_i(stat_we), .stat_wdata_i(stat_wdata), .stat_o(stat),
    .alarm2_match_i(match), .wake_i(wake),
    .pwr_en_o(pwr_en), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [31:0] v);
    cfg_we = 1'b1; cfg_wdata = v; step(); cfg_we = 1'b0;
  endtask

  task automatic wr_irq(input logic [7:0] v);
    irq_we = 1'b1; irq_wdata = v; step(); irq_we = 1'b0;
  endtask

  task automatic wr_stat(input logic [7:0] v);
    stat_we = 1'b1; stat_wdata = v; step(); stat_we = 1'b0;
  endtask

  task automatic pulse_match();
    match = 1'b1; step(); match = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pwr_en", 32'(pwr_en), 32'h1);
    chk("R1 cfg", cfg_rdata, 32'h0000_00F0);
    chk("R1 irq_en", 32'(irq_en), 32'h0);
    chk("R1 stat", 32'(stat), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_cfg_rw();
    wr_cfg(32'hFFFF_FFFF);
    chk("R2 stored bits", cfg_rdata, 32'h0001_00FF);
    wr_cfg(32'h0000_00F0);
    chk("R2 rewrite", cfg_rdata, 32'h0000_00F0);
  endtask

  task automatic t_alarm_gated();
    wr_cfg(32'h0001_00F0);
    pulse_match();
    chk("R5 pin", 32'(pwr_en), 32'h1);
    chk("R5 flag", 32'(stat), 32'h0);
    wr_irq(8'hFF);
    chk("R7 irq_en bits", 32'(irq_en), 32'h10);
  endtask

  task automatic t_hold_on();
    wr_cfg(32'h0000_00F0);
    pulse_match();
    chk("R3 pin held", 32'(pwr_en), 32'h1);
    chk("R6 flag set", 32'(stat), 32'h80);
    chk("R7 irq on", 32'(irq), 32'h1);
    wr_stat(8'h7F);
    chk("R6 no clear", 32'(stat), 32'h80);
    wr_irq(8'h00);
    chk("R7 irq masked", 32'(irq), 32'h0);
    wr_stat(8'h80);
    chk("R6 cleared", 32'(stat), 32'h0);
    wr_irq(8'h10);
  endtask

  task automatic t_alarm_off();
    wr_cfg(32'h0001_00F0);
    pulse_match();
    chk("R4 pin off", 32'(pwr_en), 32'h0);
    step(5);
    chk("R11 stays off", 32'(pwr_en), 32'h0);
    wake = 4'h0;
    step(4);
    chk("R9 disabled ignored", 32'(pwr_en), 32'h0);
    wake = 4'hF;
    step(3);
    wr_stat(8'h80);
  endtask

  task automatic t_wake_low();
    wr_cfg(32'h0001_00F1);
    chk("R11 off after cfg", 32'(pwr_en), 32'h0);
    wake = 4'hE;
    step(2);
    chk("R8 not yet", 32'(pwr_en), 32'h0);
    step(1);
    chk("R8 woke", 32'(pwr_en), 32'h1);
    wake = 4'hF;
    step(3);
  endtask

  task automatic t_wake_high();
    wake = 4'hB;
    step(3);
    wr_cfg(32'h0001_00B4);
    pulse_match();
    chk("R4 off again", 32'(pwr_en), 32'h0);
    step(4);
    chk("R9 inactive low", 32'(pwr_en), 32'h0);
    wake = 4'hF;
    step(3);
    chk("R9 active high woke", 32'(pwr_en), 32'h1);
    wr_stat(8'h80);
  endtask

  task automatic t_race();
    step(2);
    pulse_match();
    chk("R10 wake wins", 32'(pwr_en), 32'h1);
    chk("R10 flag still set", 32'(stat), 32'h80);
    stat_we = 1'b1; stat_wdata = 8'h80; match = 1'b1;
    step();
    stat_we = 1'b0; match = 1'b0;
    chk("R6 set beats clear", 32'(stat), 32'h80);
    wr_stat(8'h80);
  endtask

  task automatic t_release();
    wake = 4'hB;
    step(3);
    pulse_match();
    chk("R4 off for release", 32'(pwr_en), 32'h0);
    wr_cfg(32'h0000_00B4);
    chk("R3 one edge", 32'(pwr_en), 32'h0);
    step(1);
    chk("R3 released", 32'(pwr_en), 32'h1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog all requirements actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_we = 0; irq_we = 0; stat_we = 0; match = 0;
    cfg_wdata = '0; irq_wdata = '0; stat_wdata = '0;
    wake = 4'hF;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_cfg_rw();
    t_alarm_gated();
    t_hold_on();
    t_alarm_off();
    t_wake_low();
    t_wake_high();
    t_race();
    t_release();
    done = 1;
    summary();
    $finish;
  end
endmodule